// File: doc/BRIEF.md
# ADC Channel Setup and Readout Sequencer

This block drives a remote sigma-delta converter through an SPI register master that sits beside it. When `start` is pulsed it captures a channel code, a rate selection and a front-end configuration word. It then runs a fixed list of register writes. The list halts any conversion already running and deselects every input. It then loads the front-end configuration and puts the converter into continuous single-cycle mode on its internal oscillator with the stored coefficients. Last, it selects the captured channel and issues the start-conversion command.

Once the converter is running, the block waits for the converter's active-low ready pin. The pin is brought through a synchroniser. Each falling edge of the pin causes exactly one read of the 24-bit result register. The value returned appears on `sample` with a one-cycle `sample_vld` strobe, unless the SPI master flags a CRC error on that read. A `stop` pulse runs a two-write halt list and returns the block to idle. If a register transaction is in flight when `stop` arrives, the halt is deferred until that transaction is acknowledged, and the remaining setup steps are dropped.

The controller has five states. **IDLE** goes to **PROGRAM** on `start`. **PROGRAM** steps through the setup list one acknowledged write at a time. It goes to **ARMED** after the last write, or to **HALT** if a stop is pending at an acknowledge. **ARMED** goes to **FETCH** on a synchronised ready fall, or to **HALT** on `stop`. **FETCH** goes back to **ARMED** on acknowledge, or to **HALT** if a stop is pending. **HALT** steps through its two writes and then returns to **IDLE**.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `req` and `sample_vld` are low and `sample` is zero.
- R2: Once `req` is raised, `req`, `req_rd`, `req_addr` and `req_wdata` hold steady until the cycle `req_ack` is sampled high. Each acknowledge completes exactly one transaction.
- R3: After `start` in IDLE, the block issues seven writes in this order, each encoded as (address, data):
  - (0x20, 0x100000)
  - (0x03, 0x000000)
  - (0x02, captured `front_cfg`)
  - (0x22, 0x010000)
  - (0x23, 0x000000)
  - (0x03, channel word)
  - (0x20, start code)
- R4: The channel word carries the captured `chan_sel` in bits 11:8, with every other bit zero.
- R5: The start code is 0x330000 when `rate_sel` is 1, 0x340000 when it is 2, and 0x310000 when it is 0 or 3.
- R6: In ARMED, each high-to-low transition of `rdy_n` leads to exactly one read (`req_rd`=1) of address 0x24 with `req_wdata` zero. A low level held for many cycles gives only one read.
- R7: When a read is acknowledged without `ack_crc_err`, `sample` takes `ack_rdata` and `sample_vld` is high for exactly the following cycle.
- R8: When a read is acknowledged with `ack_crc_err` high, no `sample_vld` strobe is produced for it.
- R9: `stop` in ARMED leads at once to two writes, (0x20, 0x100000) then (0x03, 0x000000), after which the block is idle.
- R10: A `stop` that arrives while a setup write is outstanding lets that write finish. The two halt writes follow, and the remaining setup writes are not issued.
- R11: `start` outside IDLE, `stop` in IDLE, and ready-pin edges outside ARMED cause no register transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: capture settings and begin setup |
| stop | input | 1 | Pulse: halt conversions and return to idle |
| chan_sel | input | CHAN_W | Input channel code placed into the selection register |
| rate_sel | input | 2 | Conversion rate choice (0/3: 10, 1: 30, 2: 50 samples/s) |
| front_cfg | input | 24 | Front-end configuration word written to address 0x02 |
| rdy_n | input | 1 | Asynchronous active-low conversion-ready pin |
| req | output | 1 | Register transaction request to the SPI master |
| req_rd | output | 1 | 1 = read, 0 = write |
| req_addr | output | 7 | Register address |
| req_wdata | output | 24 | Write data (zero on reads) |
| req_ack | input | 1 | One-cycle completion pulse from the SPI master |
| ack_rdata | input | 24 | Read data valid with `req_ack` |
| ack_crc_err | input | 1 | CRC mismatch on the read, valid with `req_ack` |
| sample | output | 24 | Latest good conversion result |
| sample_vld | output | 1 | One-cycle strobe for a new `sample` |

## Verification
A halt request and an in-flight register transaction can coincide. The bench lets the SPI model hold back its acknowledge for several cycles. It pulses `stop` while the third setup write is still waiting. The scoreboard then expects the stalled write to complete unchanged, followed directly by the two halt writes and nothing else. Any setup write issued after the stop, or any altered request field while the acknowledge is pending, shows up as a mismatch or an unexpected request. The same bench also drives a ready fall during setup, to confirm that the fall does not leak into a read once the block reaches ARMED.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ADDR_W    = 7;
    localparam int WORD_W    = 24;
    localparam int RATE_W    = 2;
    localparam int SETUP_LEN = 7;
    localparam int HALT_LEN  = 2;
    localparam int STEP_W    = $clog2(SETUP_LEN);
    localparam int CHAN_LSB  = 8;

    // Register addresses that the remote converter decodes
    localparam logic [ADDR_W-1:0] RA_CONV_CMD = 7'h20;
    localparam logic [ADDR_W-1:0] RA_CH_SEL   = 7'h03;
    localparam logic [ADDR_W-1:0] RA_FRONT    = 7'h02;
    localparam logic [ADDR_W-1:0] RA_MODE_A   = 7'h22;
    localparam logic [ADDR_W-1:0] RA_MODE_B   = 7'h23;
    localparam logic [ADDR_W-1:0] RA_RESULT   = 7'h24;

    localparam logic [WORD_W-1:0] W_HALT_CONV = 24'h100000;
    localparam logic [WORD_W-1:0] W_CONT_MODE = 24'h010000;
    localparam logic [WORD_W-1:0] W_GO_SLOW   = 24'h310000;
    localparam logic [WORD_W-1:0] W_GO_MID    = 24'h330000;
    localparam logic [WORD_W-1:0] W_GO_FAST   = 24'h340000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROGRAM,
        ST_ARMED,
        ST_FETCH,
        ST_HALT
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } reg_op_t;

    function automatic logic [WORD_W-1:0] go_word(input logic [RATE_W-1:0] sel);
        case (sel)
            2'd1:    return W_GO_MID;
            2'd2:    return W_GO_FAST;
            default: return W_GO_SLOW;
        endcase
    endfunction

endpackage

// File: rtl/adc_ready_edge.sv
module adc_ready_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n,
    output logic fall
);
    // pipe[STAGES-1:0] synchronise, pipe[STAGES] holds the previous settled level
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], rdy_n};
        end
    end

    assign fall = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/adc_script_rom.sv
module adc_script_rom
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic [STEP_W-1:0] step,
    input  logic [CHAN_W-1:0] chan,
    input  logic [RATE_W-1:0] rate,
    input  logic [WORD_W-1:0] front_cfg,
    output reg_op_t           op
);
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        sel_word[CHAN_LSB +: CHAN_W] = chan;
    end

    // Steps 0 and 1 double as the whole halt list
    always_comb begin
        op = '0;
        case (step)
            3'd0:    op = '{addr: RA_CONV_CMD, data: W_HALT_CONV};
            3'd1:    op = '{addr: RA_CH_SEL,   data: '0};
            3'd2:    op = '{addr: RA_FRONT,    data: front_cfg};
            3'd3:    op = '{addr: RA_MODE_A,   data: W_CONT_MODE};
            3'd4:    op = '{addr: RA_MODE_B,   data: '0};
            3'd5:    op = '{addr: RA_CH_SEL,   data: sel_word};
            3'd6:    op = '{addr: RA_CONV_CMD, data: go_word(rate)};
            default: op = '0;
        endcase
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic [1:0]        rate_sel,
    input  logic [23:0]       front_cfg,
    input  logic              rdy_n,
    output logic              req,
    output logic              req_rd,
    output logic [6:0]        req_addr,
    output logic [23:0]       req_wdata,
    input  logic              req_ack,
    input  logic [23:0]       ack_rdata,
    input  logic              ack_crc_err,
    output logic [23:0]       sample,
    output logic              sample_vld
);
    localparam logic [STEP_W-1:0] SETUP_LAST = STEP_W'(SETUP_LEN - 1);
    localparam logic [STEP_W-1:0] HALT_LAST  = STEP_W'(HALT_LEN - 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              stop_pend_q, stop_pend_d;
    logic              stop_req;
    logic [CHAN_W-1:0] chan_q;
    logic [RATE_W-1:0] rate_q;
    logic [WORD_W-1:0] cfg_q;
    logic              rdy_fall;
    reg_op_t           rom_op;

    adc_ready_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rdy_n (rdy_n),
        .fall  (rdy_fall)
    );

    adc_script_rom #(.CHAN_W(CHAN_W)) u_rom (
        .step      (step_q),
        .chan      (chan_q),
        .rate      (rate_q),
        .front_cfg (cfg_q),
        .op        (rom_op)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            step_q      <= '0;
            stop_pend_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            step_q      <= step_d;
            stop_pend_q <= stop_pend_d;
        end
    end

    // Settings captured at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            rate_q <= '0;
            cfg_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            chan_q <= chan_sel;
            rate_q <= rate_sel;
            cfg_q  <= front_cfg;
        end
    end

    assign stop_req = stop_pend_q | stop;

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        step_d      = step_q;
        stop_pend_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PROGRAM;
                    step_d  = '0;
                end
            end
            ST_PROGRAM: begin
                stop_pend_d = stop_req;
                if (req_ack) begin
                    if (stop_req) begin
                        state_d     = ST_HALT;
                        step_d      = '0;
                        stop_pend_d = 1'b0;
                    end else if (step_q == SETUP_LAST) begin
                        state_d = ST_ARMED;
                        step_d  = '0;
                    end else begin
                        step_d = step_q + 1'b1;
                    end
                end
            end
            ST_ARMED: begin
                if (stop) begin
                    state_d = ST_HALT;
                    step_d  = '0;
                end else if (rdy_fall) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                stop_pend_d = stop_req;
                if (req_ack) begin
                    stop_pend_d = 1'b0;
                    if (stop_req) begin
                        state_d = ST_HALT;
                        step_d  = '0;
                    end else begin
                        state_d = ST_ARMED;
                    end
                end
            end
            ST_HALT: begin
                if (req_ack) begin
                    if (step_q == HALT_LAST) begin
                        state_d = ST_IDLE;
                        step_d  = '0;
                    end else begin
                        step_d = step_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                step_d  = '0;
            end
        endcase
    end

    // Request outputs
    always_comb begin
        req       = 1'b0;
        req_rd    = 1'b0;
        req_addr  = rom_op.addr;
        req_wdata = rom_op.data;
        unique case (state_q)
            ST_PROGRAM, ST_HALT: req = 1'b1;
            ST_FETCH: begin
                req       = 1'b1;
                req_rd    = 1'b1;
                req_addr  = RA_RESULT;
                req_wdata = '0;
            end
            default: req = 1'b0;
        endcase
    end

    // Result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample     <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= 1'b0;
            if (state_q == ST_FETCH && req_ack && !ack_crc_err) begin
                sample     <= ack_rdata;
                sample_vld <= 1'b1;
            end
        end
    end

    // R2: request fields hold until acknowledged
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_ack) |=> (req && $stable(req_rd) && $stable(req_addr) && $stable(req_wdata)));

    // R6: a new read only follows a synchronised ready fall
    a_r6_read_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_rd && !$past(req && req_rd)) |-> $past(rdy_fall));

    // R7: strobe follows an acknowledged read, carrying its data
    a_r7_strobe_data: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> ($past(req && req_rd && req_ack) && sample == $past(ack_rdata)));

    // R8: no strobe for a read flagged with a CRC error
    a_r8_crc_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> !$past(ack_crc_err));

    // R9: stop while armed starts the halt write at once
    a_r9_stop_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && stop) |=> (req && !req_rd && req_addr == RA_CONV_CMD && req_wdata == W_HALT_CONV));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    import adc_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n, start, stop, rdy_n;
    logic [3:0]  chan_sel;
    logic [1:0]  rate_sel;
    logic [23:0] front_cfg;
    logic        req, req_rd, req_ack, ack_crc_err, sample_vld;
    logic [6:0]  req_addr;
    logic [23:0] req_wdata, ack_rdata, sample;

    always #5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .chan_sel(chan_sel), .rate_sel(rate_sel), .front_cfg(front_cfg),
        .rdy_n(rdy_n), .req(req), .req_rd(req_rd), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .ack_rdata(ack_rdata),
        .ack_crc_err(ack_crc_err), .sample(sample), .sample_vld(sample_vld)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    int          txn_seen = 0;
    int          vld_seen = 0;
    int          ack_delay = 3;
    logic [23:0] rd_value = '0;
    logic        rd_crc = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] smp_q[$];
    logic [23:0] smp_e;

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Scoreboard side: SPI master model compares each request with the queue
    initial begin
        logic [31:0] got, e;
        string       t;
        bit          steady;
        req_ack = 1'b0; ack_rdata = '0; ack_crc_err = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && req) begin
                got = {req_rd, req_addr, req_rd ? 24'h0 : req_wdata};
                txn_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R11 unexpected request", got, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got == e, t, got, e);
                end
                steady = 1;
                repeat (ack_delay) begin
                    @(negedge clk);
                    if (!req || {req_rd, req_addr, req_rd ? 24'h0 : req_wdata} != got) steady = 0;
                end
                check(steady, "R2 request held until ack", {31'h0, steady}, 32'h1);
                if (req_rd) begin
                    ack_rdata   = rd_value;
                    ack_crc_err = rd_crc;
                    if (!rd_crc) smp_q.push_back(rd_value);
                end
                req_ack = 1'b1;
                @(negedge clk);
                req_ack = 1'b0;
                ack_crc_err = 1'b0;
            end
        end
    end

    // Monitor: result strobes against expected samples
    always @(negedge clk) begin
        if (rst_n && sample_vld) begin
            vld_seen++;
            if (smp_q.size() == 0) begin
                check(0, "R8 unexpected sample strobe", {8'h0, sample}, 32'h0);
            end else begin
                smp_e = smp_q.pop_front();
                check(sample == smp_e, "R7 sample value", {8'h0, sample}, {8'h0, smp_e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_up();
        end
    end

    task automatic exp_wr(input logic [6:0] a, input logic [23:0] d, input string t);
        exp_q.push_back({1'b0, a, d});
        tag_q.push_back(t);
    endtask

    task automatic exp_halt(input string t);
        exp_wr(7'h20, 24'h100000, t);
        exp_wr(7'h03, 24'h000000, t);
    endtask

    function automatic logic [23:0] go_code(input logic [1:0] r);
        return (r == 2'd1) ? 24'h330000 : (r == 2'd2) ? 24'h340000 : 24'h310000;
    endfunction

    task automatic exp_setup(input logic [3:0] ch, input logic [1:0] r, input logic [23:0] cfg, input int upto);
        logic [6:0]  a[7];
        logic [23:0] d[7];
        a[0] = 7'h20; d[0] = 24'h100000;
        a[1] = 7'h03; d[1] = 24'h000000;
        a[2] = 7'h02; d[2] = cfg;
        a[3] = 7'h22; d[3] = 24'h010000;
        a[4] = 7'h23; d[4] = 24'h000000;
        a[5] = 7'h03; d[5] = {12'h0, ch, 8'h00};
        a[6] = 7'h20; d[6] = go_code(r);
        for (int i = 0; i < upto; i++)
            exp_wr(a[i], d[i], (i == 5) ? "R4 channel word" : (i == 6) ? "R5 start code" : "R3 setup order");
    endtask

    task automatic pulse_start(input logic [3:0] ch, input logic [1:0] r, input logic [23:0] cfg);
        @(negedge clk);
        chan_sel = ch; rate_sel = r; front_cfg = cfg; start = 1'b1;
        @(negedge clk);
        start = 1'b0; chan_sel = 4'hF; rate_sel = 2'd3; front_cfg = 24'hFFFFFF;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic settle();
        int q = 0;
        while (q < 6) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !req && !req_ack) q++;
            else q = 0;
        end
    endtask

    task automatic ready_event(input logic [23:0] d, input logic crc, input int low, input bit expect_read);
        rd_value = d; rd_crc = crc;
        if (expect_read) begin
            exp_q.push_back({1'b1, 7'h24, 24'h0});
            tag_q.push_back("R6 result read");
        end
        @(negedge clk); rdy_n = 1'b0;
        repeat (low) @(negedge clk);
        rdy_n = 1'b1;
        settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int base;
        int vb;
        rst_n = 1'b0; start = 1'b0; stop = 1'b0; rdy_n = 1'b1;
        chan_sel = '0; rate_sel = '0; front_cfg = '0;
        repeat (4) @(negedge clk);
        check(!req && !sample_vld && sample == 0, "R1 reset state", {7'h0, req, sample_vld, sample}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!req && !sample_vld && sample == 0, "R1 after reset", {7'h0, req, sample_vld, sample}, 32'h0);

        // R3/R4/R5: setup, channel 1, slow rate
        exp_setup(4'h1, 2'd0, 24'h006000, 7);
        pulse_start(4'h1, 2'd0, 24'h006000);
        settle();

        // R6/R7: long low level gives exactly one read
        ready_event(24'hABCDEF, 1'b0, 12, 1);
        check(txn_seen == 8, "R6 one read per fall", txn_seen, 8);

        // R8: CRC error drops the strobe
        vb = vld_seen;
        ready_event(24'h800001, 1'b1, 3, 1);
        check(vld_seen == vb, "R8 no strobe on crc error", vld_seen, vb);
        check(sample == 24'hABCDEF, "R8 sample unchanged", {8'h0, sample}, 32'hABCDEF);

        // R11: start while armed ignored
        base = txn_seen;
        pulse_start(4'h2, 2'd1, 24'h0);
        repeat (20) @(negedge clk);
        check(txn_seen == base, "R11 start ignored outside idle", txn_seen, base);

        // R9: stop while armed
        exp_halt("R9 halt list");
        pulse_stop();
        settle();
        base = txn_seen;
        pulse_stop();
        ready_event(24'h111111, 1'b0, 3, 0);
        check(txn_seen == base, "R11 stop and ready ignored in idle", txn_seen, base);

        // R4/R5/R7: PGA-path channel, mid rate
        exp_setup(4'hC, 2'd1, 24'h000440, 7);
        pulse_start(4'hC, 2'd1, 24'h000440);
        settle();
        ready_event(24'h123456, 1'b0, 2, 1);
        exp_halt("R9 halt list");
        pulse_stop();
        settle();

        // R10: stop while the third setup write awaits its ack
        ack_delay = 6;
        base = txn_seen;
        exp_setup(4'h3, 2'd2, 24'h008000, 3);
        pulse_start(4'h3, 2'd2, 24'h008000);
        while (txn_seen < base + 3) @(negedge clk);
        exp_halt("R10 deferred halt");
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        settle();
        check(txn_seen == base + 5, "R10 remaining setup dropped", txn_seen, base + 5);
        ack_delay = 3;

        // R5/R11: rate 3 gives slow code; fall during setup ignored
        base = txn_seen;
        exp_setup(4'h5, 2'd3, 24'h001800, 7);
        pulse_start(4'h5, 2'd3, 24'h001800);
        @(negedge clk);
        rdy_n = 1'b0;
        settle();
        repeat (10) @(negedge clk);
        check(txn_seen == base + 7, "R11 fall during setup ignored", txn_seen, base + 7);
        rdy_n = 1'b1;
        repeat (6) @(negedge clk);
        ready_event(24'hFEDCBA, 1'b0, 4, 1);
        exp_halt("R9 halt list");
        pulse_stop();
        settle();

        check(exp_q.size() == 0, "R3 all requests seen", exp_q.size(), 0);
        check(smp_q.size() == 0, "R7 all samples seen", smp_q.size(), 0);
        finish_up();
    end

endmodule